// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit buses, called A and B. It moves data in either direction, and each direction has a capture register with its own clock. For each direction a select input decides what the driven bus receives. It can receive the live value on the opposite bus, or the word last captured by that direction's register. Each direction also has its own output enable, and the two enables have opposite polarity. The bus pads are three-state, so each bus is modelled as three signals: an input vector, an output data vector and a per-bit drive vector. The surrounding pad ring resolves them.

The 16 bits are split into two 8-bit groups. Each group has its own pair of clocks, its own pair of selects and its own pair of enables, so each group works as a separate transceiver. A register always captures on the rising edge of its clock, whatever the select and enable levels are. A word can therefore be loaded while a direction is isolated and presented later.

Top module: `dual_bus_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab[g]`, the A-to-B register of group g loads `a_in` bits [8g+7:8g], whatever the select and enable levels are.
- R2: On each rising edge of `clk_ba[g]`, the B-to-A register of group g loads `b_in` bits [8g+7:8g], whatever the select and enable levels are.
- R3: For each direction, a select level of 0 sends the live opposite-bus bits to the output data, and a level of 1 sends that direction's stored word. The output data always carries this chosen value, whether or not the bus is driven.
- R4: `b_drv` bits of group g are all 1 when `oe_ab[g]` is 1 (active high), and all 0 when it is 0.
- R5: `a_drv` bits of group g are all 1 when `oe_ba_n[g]` is 0 (active low), and all 0 when it is 1.
- R6: With `oe_ab[g]`=0 and `oe_ba_n[g]`=1, neither bus is driven in group g. Both registers still load, and the loaded words appear on the outputs once the selects are 1 and the enables become active.
- R7: With `oe_ab[g]`=1, `oe_ba_n[g]`=0 and both selects at 1, the stored A word drives B and the stored B word drives A at the same time.
- R8: The clocks, selects and enables of one group have no effect on the registers, data or drive of the other group.
- R9: While `rst_n` is 0, every register holds zero, clock edges are ignored, and no bus bit is driven, whatever the enable levels are.
- R10: With both directions enabled and both selects at 0, B shows the live A bits and A shows the live B bits, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_ab | input | 2 | A-to-B capture clock, one per group |
| clk_ba | input | 2 | B-to-A capture clock, one per group |
| sel_ab | input | 2 | B-side source per group: 0 live A, 1 stored |
| sel_ba | input | 2 | A-side source per group: 0 live B, 1 stored |
| oe_ab | input | 2 | Drive bus B, active high, per group |
| oe_ba_n | input | 2 | Drive bus A, active low, per group |
| a_in | input | 16 | Value seen on bus A |
| a_out | output | 16 | Data presented to bus A |
| a_drv | output | 16 | Per-bit drive enable for bus A |
| b_in | input | 16 | Value seen on bus B |
| b_out | output | 16 | Data presented to bus B |
| b_drv | output | 16 | Per-bit drive enable for bus B |

## Verification
The assertions are sampled on each group's capture clock and check the following:
- each edge loads the opposite bus word into the register;
- the output data follows the live or stored source that the select names;
- the drive vectors match the enable polarity;
- reset keeps the registers zero and both buses undriven.

Some behaviour only the bench's scenarios can show. These cover words loaded during isolation and presented later, and the two groups staying apart while one is swept through all sixteen control combinations. They also cover captures under staggered versus simultaneous clocks, and live values that change after a capture.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;

  localparam logic AB_EN_LEVEL = 1'b1;
  localparam logic BA_EN_LEVEL = 1'b0;

  // A direction drives only when out of reset and its enable sits at its active level.
  function automatic logic path_on(input logic oe_level, input logic active_level,
                                   input logic rst_n);
    return rst_n && (oe_level == active_level);
  endfunction

  function automatic src_e src_of(input logic sel);
    return (sel == 1'b1) ? SRC_HELD : SRC_LIVE;
  endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic         drive_on,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] data,
  output logic [W-1:0] drv
);
  src_e src;

  // Both mux legs are stable signals, so a select change alters data in one step.
  always_comb begin
    src  = src_of(sel);
    data = (src == SRC_HELD) ? held : live;
    drv  = {W{drive_on}};
  end
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv,
  output logic [W-1:0] ab_held,
  output logic [W-1:0] ba_held
);
  logic drive_b;
  logic drive_a;

  assign drive_b = path_on(oe_ab,   AB_EN_LEVEL, rst_n);
  assign drive_a = path_on(oe_ba_n, BA_EN_LEVEL, rst_n);

  xcvr_capture #(.W(W)) u_cap_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(ab_held)
  );

  xcvr_capture #(.W(W)) u_cap_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(ba_held)
  );

  xcvr_path #(.W(W)) u_path_b (
    .sel(sel_ab), .drive_on(drive_b), .live(a_in), .held(ab_held),
    .data(b_out), .drv(b_drv)
  );

  xcvr_path #(.W(W)) u_path_a (
    .sel(sel_ba), .drive_on(drive_a), .live(b_in), .held(ba_held),
    .data(a_out), .drv(a_drv)
  );
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int GROUPS = 2,
  parameter int GRP_W  = 8
) (
  input  logic                      rst_n,
  input  logic [GROUPS-1:0]         clk_ab,
  input  logic [GROUPS-1:0]         clk_ba,
  input  logic [GROUPS-1:0]         sel_ab,
  input  logic [GROUPS-1:0]         sel_ba,
  input  logic [GROUPS-1:0]         oe_ab,
  input  logic [GROUPS-1:0]         oe_ba_n,
  input  logic [GROUPS*GRP_W-1:0]   a_in,
  output logic [GROUPS*GRP_W-1:0]   a_out,
  output logic [GROUPS*GRP_W-1:0]   a_drv,
  input  logic [GROUPS*GRP_W-1:0]   b_in,
  output logic [GROUPS*GRP_W-1:0]   b_out,
  output logic [GROUPS*GRP_W-1:0]   b_drv
);
  localparam int W = GROUPS * GRP_W;

  // Register contents brought out as named wires for the checker.
  logic [W-1:0] ab_held_all;
  logic [W-1:0] ba_held_all;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    xcvr_group #(.W(GRP_W)) u_group (
      .rst_n   (rst_n),
      .clk_ab  (clk_ab[g]),
      .clk_ba  (clk_ba[g]),
      .sel_ab  (sel_ab[g]),
      .sel_ba  (sel_ba[g]),
      .oe_ab   (oe_ab[g]),
      .oe_ba_n (oe_ba_n[g]),
      .a_in    (a_in[g*GRP_W +: GRP_W]),
      .b_in    (b_in[g*GRP_W +: GRP_W]),
      .a_out   (a_out[g*GRP_W +: GRP_W]),
      .a_drv   (a_drv[g*GRP_W +: GRP_W]),
      .b_out   (b_out[g*GRP_W +: GRP_W]),
      .b_drv   (b_drv[g*GRP_W +: GRP_W]),
      .ab_held (ab_held_all[g*GRP_W +: GRP_W]),
      .ba_held (ba_held_all[g*GRP_W +: GRP_W])
    );
  end
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int GROUPS = 2,
  parameter int GRP_W  = 8
) (
  input logic                    rst_n,
  input logic [GROUPS-1:0]       clk_ab,
  input logic [GROUPS-1:0]       clk_ba,
  input logic [GROUPS-1:0]       sel_ab,
  input logic [GROUPS-1:0]       sel_ba,
  input logic [GROUPS-1:0]       oe_ab,
  input logic [GROUPS-1:0]       oe_ba_n,
  input logic [GROUPS*GRP_W-1:0] a_in,
  input logic [GROUPS*GRP_W-1:0] a_out,
  input logic [GROUPS*GRP_W-1:0] a_drv,
  input logic [GROUPS*GRP_W-1:0] b_in,
  input logic [GROUPS*GRP_W-1:0] b_out,
  input logic [GROUPS*GRP_W-1:0] b_drv,
  input logic [GROUPS*GRP_W-1:0] ab_held,
  input logic [GROUPS*GRP_W-1:0] ba_held
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    localparam int LO = g * GRP_W;

    p_cap_ab_r1: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
      1'b1 |=> ab_held[LO +: GRP_W] == $past(a_in[LO +: GRP_W]));

    p_cap_ba_r2: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
      1'b1 |=> ba_held[LO +: GRP_W] == $past(b_in[LO +: GRP_W]));

    p_b_live_r3: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
      !sel_ab[g] |-> b_out[LO +: GRP_W] == a_in[LO +: GRP_W]);

    p_b_held_r3: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
      sel_ab[g] |-> b_out[LO +: GRP_W] == ab_held[LO +: GRP_W]);

    p_a_live_r3: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
      !sel_ba[g] |-> a_out[LO +: GRP_W] == b_in[LO +: GRP_W]);

    p_a_held_r3: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
      sel_ba[g] |-> a_out[LO +: GRP_W] == ba_held[LO +: GRP_W]);

    p_b_quiet_r4: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
      !oe_ab[g] |-> b_drv[LO +: GRP_W] == '0);

    p_b_drive_r4: assert property (@(posedge clk_ab[g]) disable iff (!rst_n)
      oe_ab[g] |-> b_drv[LO +: GRP_W] == '1);

    p_a_quiet_r5: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
      oe_ba_n[g] |-> a_drv[LO +: GRP_W] == '0);

    p_a_drive_r5: assert property (@(posedge clk_ba[g]) disable iff (!rst_n)
      !oe_ba_n[g] |-> a_drv[LO +: GRP_W] == '1);

    p_reset_ab_r9: assert property (@(posedge clk_ab[g])
      !rst_n |-> (ab_held[LO +: GRP_W] == '0) && (b_drv[LO +: GRP_W] == '0));

    p_reset_ba_r9: assert property (@(posedge clk_ba[g])
      !rst_n |-> (ba_held[LO +: GRP_W] == '0) && (a_drv[LO +: GRP_W] == '0));
  end
endmodule

bind dual_bus_xcvr xcvr_checker #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_xcvr_chk (
  .rst_n   (rst_n),
  .clk_ab  (clk_ab),
  .clk_ba  (clk_ba),
  .sel_ab  (sel_ab),
  .sel_ba  (sel_ba),
  .oe_ab   (oe_ab),
  .oe_ba_n (oe_ba_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_drv   (a_drv),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_drv   (b_drv),
  .ab_held (ab_held_all),
  .ba_held (ba_held_all)
);

// File: tb/dual_bus_xcvr_bench.sv
module dual_bus_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GROUPS = 2;
  localparam int GRP_W  = 8;
  localparam int W = GROUPS * GRP_W;

  logic              rst_n;
  logic [GROUPS-1:0] clk_ab, clk_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
  logic [W-1:0]      a_in, b_in;
  logic [W-1:0]      a_out, a_drv, b_out, b_drv;

  int checks = 0;
  int errors = 0;
  logic [GRP_W-1:0] m_ab [GROUPS];
  logic [GRP_W-1:0] m_ba [GROUPS];

  dual_bus_xcvr #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_dual_bus_xcvr (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv)
  );

  task automatic chk(input string tag, input logic [GRP_W-1:0] act, input logic [GRP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Words that no group slice can confuse: computed from group, case, pass and side.
  function automatic logic [GRP_W-1:0] word(input int g, input int c, input int p, input int side);
    return GRP_W'(g * 97 + c * 13 + p * 41 + side * 29 + 5);
  endfunction

  // Rising edge on the chosen clocks of group g; the model loads at the same edge.
  task automatic pulse(input int g, input bit do_ab, input bit do_ba);
    if (do_ab) clk_ab[g] = 1'b1;
    if (do_ba) clk_ba[g] = 1'b1;
    if (do_ab) m_ab[g] = a_in[g*GRP_W +: GRP_W];
    if (do_ba) m_ba[g] = b_in[g*GRP_W +: GRP_W];
    #(CLK_PERIOD/2);
    clk_ab[g] = 1'b0;
    clk_ba[g] = 1'b0;
    #(CLK_PERIOD/2);
  endtask

  task automatic verify(input int g, input string side_tag);
    logic [GRP_W-1:0] eb, ea, ebd, ead;
    #1;
    eb  = sel_ab[g] ? m_ab[g] : a_in[g*GRP_W +: GRP_W];
    ea  = sel_ba[g] ? m_ba[g] : b_in[g*GRP_W +: GRP_W];
    ebd = oe_ab[g]   ? '1 : '0;
    ead = oe_ba_n[g] ? '0 : '1;
    chk({side_tag, " R1 R3 b_out"}, b_out[g*GRP_W +: GRP_W], eb);
    chk({side_tag, " R2 R3 a_out"}, a_out[g*GRP_W +: GRP_W], ea);
    chk({side_tag, " R4 b_drv"},    b_drv[g*GRP_W +: GRP_W], ebd);
    chk({side_tag, " R5 a_drv"},    a_drv[g*GRP_W +: GRP_W], ead);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_ab = '0; clk_ba = '0;
    sel_ab = '1; sel_ba = '1; oe_ab = '1; oe_ba_n = '0;
    a_in = 16'h5AC3; b_in = 16'h96E1;
    for (int g = 0; g < GROUPS; g++) begin m_ab[g] = '0; m_ba[g] = '0; end
    #(CLK_PERIOD);
    // R9: edges in reset are ignored, registers read zero, nothing driven
    clk_ab[0] = 1'b1; clk_ba[0] = 1'b1; #(CLK_PERIOD/2);
    clk_ab[0] = 1'b0; clk_ba[0] = 1'b0; #(CLK_PERIOD/2);
    for (int g = 0; g < GROUPS; g++) begin
      chk("R9 reset b_out", b_out[g*GRP_W +: GRP_W], '0);
      chk("R9 reset a_out", a_out[g*GRP_W +: GRP_W], '0);
      chk("R9 reset b_drv", b_drv[g*GRP_W +: GRP_W], '0);
      chk("R9 reset a_drv", a_drv[g*GRP_W +: GRP_W], '0);
    end
    rst_n = 1'b1;
    #(CLK_PERIOD);
    for (int g = 0; g < GROUPS; g++) verify(g, "R9 after reset");

    // Sweep: every control combination of one group, three clocking patterns.
    for (int g = 0; g < GROUPS; g++) begin
      for (int c = 0; c < 16; c++) begin
        for (int p = 0; p < 3; p++) begin
          int o;
          o = 1 - g;
          sel_ab[g] = c[0]; sel_ba[g] = c[1]; oe_ab[g] = c[2]; oe_ba_n[g] = c[3];
          sel_ab[o] = 1'b1; sel_ba[o] = 1'b1; oe_ab[o] = 1'b1; oe_ba_n[o] = 1'b0;
          a_in[g*GRP_W +: GRP_W] = word(g, c, p, 0);
          b_in[g*GRP_W +: GRP_W] = word(g, c, p, 1);
          #1;
          pulse(g, p != 1, p != 0);
          a_in[g*GRP_W +: GRP_W] = ~word(g, c, p, 2);
          b_in[g*GRP_W +: GRP_W] = ~word(g, c, p, 3);
          verify(g, "sweep");
          verify(o, "R8 other group");
        end
      end
    end

    // R6: load while isolated, then present the stored words
    sel_ab[0] = 1'b1; sel_ba[0] = 1'b1; oe_ab[0] = 1'b0; oe_ba_n[0] = 1'b1;
    a_in[7:0] = 8'h3C; b_in[7:0] = 8'hA5;
    #1;
    pulse(0, 1'b1, 1'b1);
    #1;
    chk("R6 isolated b_drv", b_drv[7:0], 8'h00);
    chk("R6 isolated a_drv", a_drv[7:0], 8'h00);
    a_in[7:0] = 8'h00; b_in[7:0] = 8'hFF;
    oe_ab[0] = 1'b1; oe_ba_n[0] = 1'b0;
    #1;
    // R7: both stored words driven at once
    chk("R6 R7 stored A on B", b_out[7:0], 8'h3C);
    chk("R6 R7 stored B on A", a_out[7:0], 8'hA5);
    chk("R7 b_drv", b_drv[7:0], 8'hFF);
    chk("R7 a_drv", a_drv[7:0], 8'hFF);

    // R10: both directions live
    sel_ab[1] = 1'b0; sel_ba[1] = 1'b0; oe_ab[1] = 1'b1; oe_ba_n[1] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      a_in[15:8] = GRP_W'(8'h11 * (k + 1));
      b_in[15:8] = GRP_W'(8'h0F ^ (k * 37));
      #2;
      chk("R10 live A on B", b_out[15:8], a_in[15:8]);
      chk("R10 live B on A", a_out[15:8], b_in[15:8]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule